// File: doc/BRIEF.md
# DMA Channel Claim and Run Control Registers

This block is the register front end for a multi-channel memory-to-memory DMA engine. It sits on a simple memory-mapped register bus. For each channel it holds a control word with a claim bit and a run bit, and a configuration word with write-size and read-size fields. It also holds three 64-bit descriptor registers: transfer byte count, destination address and source address.

Software must claim a channel before it can run it. Claiming a free channel wipes the descriptor. A run request on an unclaimed channel is dropped. A channel cannot be released while a transfer is in flight.

An accepted run request produces a one-cycle start pulse for the transfer engine, together with the latched descriptor. The engine answers with a done pulse, and that pulse ends the run.

The bus address is split into fields:
- bits [4:0] select the register inside a channel's 32-byte window;
- the bits above them select the channel.

Register read data is registered: it is valid on the cycle after the read strobe.

Top module: `dma_claim_ctrl`

## Requirements
- R1: After reset every register of every channel reads 0 and `start_o` is 0.
- R2: Word offsets within a channel window map as follows:
  - 0x00 is control, holding claim in bit 0 and run in bit 1, with other bits reading 0.
  - 0x04 is configuration, holding write size in bits 31:28 and read size in bits 27:24, with other bits reading 0.
  - 0x08/0x0C hold the low/high words of the byte count.
  - 0x10/0x14 hold the low/high words of the destination address.
  - 0x18/0x1C hold the low/high words of the source address.
  - Read data appears on `bus_rdata` the cycle after `bus_rd`.
- R3: A control write with bit 0 = 1 to a channel whose claim is 0 sets claim and clears the byte count, destination and source registers to 0.
- R4: A control write with run = 1 to a channel that was not already claimed produces no start pulse, and run reads back 0.
- R5: A control write with claim = 1 and run = 1 to a claimed, idle channel starts a transfer. The starting channel's bit of `start_o` is high for exactly one cycle, the cycle after the write. In that cycle the descriptor outputs carry that channel's byte count, destination, source and size fields.
- R6: While run is 1, control writes have no effect. In particular, writing claim = 0 leaves claim at 1.
- R7: A control write with claim = 0 to an idle channel stores run = 0 and starts nothing, even if the written run bit is 1. Writing 0 to an idle claimed channel makes control read back 0.
- R8: A `done_i` pulse on a running channel clears run and leaves claim at 1. A `done_i` pulse on an idle channel changes nothing.
- R9: While run is 1, writes to the configuration and descriptor registers of that channel are ignored.
- R10: Writes to a channel index at or above `NCH` are ignored, and reads of such an index return 0.
- R11: At most one bit of `start_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | CHW+5 | Byte address: channel index above bit 4, register offset in bits 4:0 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| done_i | input | NCH | Per-channel transfer-complete pulse from the engine |
| start_o | output | NCH | Per-channel one-cycle start pulse |
| start_bytes_o | output | 64 | Byte count of the starting channel |
| start_dst_o | output | 64 | Destination address of the starting channel |
| start_src_o | output | 64 | Source address of the starting channel |
| start_wsize_o | output | 4 | Write-size field (2^n bytes) of the starting channel |
| start_rsize_o | output | 4 | Read-size field (2^n bytes) of the starting channel |

## Verification
A wrong claim or run bit becomes visible at the ports in one of two ways. It shows up on the next control read one cycle later. It also shows up as a missing or extra start pulse the cycle after the control write that should or should not have started the channel. A descriptor register that failed to clear on claim, or that accepted a write during a run, shows up in the descriptor values carried with the next start pulse, or on the next read of that offset. The bench keeps a model of every channel. It interleaves random writes, reads and done pulses on all channels, including the out-of-range index, so a divergence is caught at the first port sample that depends on it.

// File: rtl/dma_claim_ctrl.sv
module dma_claim_ctrl #(
  parameter int NCH = 3,
  parameter int CHW = 2,
  localparam int AW = CHW + 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [AW-1:0]  bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  input  logic [NCH-1:0] done_i,
  output logic [NCH-1:0] start_o,
  output logic [63:0]    start_bytes_o,
  output logic [63:0]    start_dst_o,
  output logic [63:0]    start_src_o,
  output logic [3:0]     start_wsize_o,
  output logic [3:0]     start_rsize_o
);

  logic [CHW-1:0] ch;
  logic [2:0]     wsel;
  logic           ch_ok;

  assign ch    = bus_addr[AW-1:5];
  assign wsel  = bus_addr[4:2];
  assign ch_ok = (32'(ch) < NCH);

  logic [NCH-1:0] claim_v, run_v, start_v;
  logic [3:0]     wsz_a [NCH];
  logic [3:0]     rsz_a [NCH];
  logic [63:0]    nb_a  [NCH];
  logic [63:0]    nd_a  [NCH];
  logic [63:0]    ns_a  [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic        claim, run;
    logic [3:0]  wsz, rsz;
    logic [63:0] nb, nd, ns;
    logic        wr_c, cw;

    assign wr_c = bus_wr && ch_ok && (ch == CHW'(g));
    assign cw   = wr_c && (wsel == 3'd0);
    assign start_v[g] = cw && !run && claim && bus_wdata[0] && bus_wdata[1];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        claim <= 1'b0;
        run   <= 1'b0;
        wsz   <= '0;
        rsz   <= '0;
        nb    <= '0;
        nd    <= '0;
        ns    <= '0;
      end else if (run) begin
        if (done_i[g]) run <= 1'b0;
      end else if (cw) begin
        claim <= bus_wdata[0];
        run   <= claim && bus_wdata[0] && bus_wdata[1];
        if (!claim && bus_wdata[0]) begin
          nb <= '0;
          nd <= '0;
          ns <= '0;
        end
      end else if (wr_c) begin
        case (wsel)
          3'd1: {wsz, rsz} <= bus_wdata[31:24];
          3'd2: nb[31:0]   <= bus_wdata;
          3'd3: nb[63:32]  <= bus_wdata;
          3'd4: nd[31:0]   <= bus_wdata;
          3'd5: nd[63:32]  <= bus_wdata;
          3'd6: ns[31:0]   <= bus_wdata;
          3'd7: ns[63:32]  <= bus_wdata;
          default: ;
        endcase
      end
    end

    assign claim_v[g] = claim;
    assign run_v[g]   = run;
    assign wsz_a[g]   = wsz;
    assign rsz_a[g]   = rsz;
    assign nb_a[g]    = nb;
    assign nd_a[g]    = nd;
    assign ns_a[g]    = ns;
  end

  logic [NCH-1:0] start_q;
  logic [CHW-1:0] sel_q;
  logic           go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      sel_q   <= '0;
    end else begin
      start_q <= start_v;
      if (|start_v) sel_q <= ch;
    end
  end

  assign go            = |start_q;
  assign start_o       = start_q;
  assign start_bytes_o = go ? nb_a[sel_q]  : '0;
  assign start_dst_o   = go ? nd_a[sel_q]  : '0;
  assign start_src_o   = go ? ns_a[sel_q]  : '0;
  assign start_wsize_o = go ? wsz_a[sel_q] : '0;
  assign start_rsize_o = go ? rsz_a[sel_q] : '0;

  logic [31:0] rd_val;

  always_comb begin
    rd_val = '0;
    if (ch_ok) begin
      case (wsel)
        3'd0: rd_val = {30'd0, run_v[ch], claim_v[ch]};
        3'd1: rd_val = {wsz_a[ch], rsz_a[ch], 24'd0};
        3'd2: rd_val = nb_a[ch][31:0];
        3'd3: rd_val = nb_a[ch][63:32];
        3'd4: rd_val = nd_a[ch][31:0];
        3'd5: rd_val = nd_a[ch][63:32];
        3'd6: rd_val = ns_a[ch][31:0];
        default: rd_val = ns_a[ch][63:32];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end

endmodule

// File: rtl/dma_claim_ctrl_chk.sv
module dma_claim_ctrl_chk #(
  parameter int NCH = 3,
  parameter int CHW = 2,
  localparam int AW = CHW + 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_wr,
  input logic           bus_rd,
  input logic [AW-1:0]  bus_addr,
  input logic [31:0]    bus_wdata,
  input logic [31:0]    bus_rdata,
  input logic [NCH-1:0] start_o
);

  logic oob, ctrl_rd, run_req;
  assign oob     = !(32'(bus_addr[AW-1:5]) < NCH);
  assign ctrl_rd = bus_rd && !oob && (bus_addr[4:2] == 3'd0);
  assign run_req = bus_wr && !oob && (bus_addr[4:2] == 3'd0) && (bus_wdata[1:0] == 2'b11);

  a_r11_start_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start_o));

  a_r5_start_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o != '0) |=> ((start_o & $past(start_o)) == '0));

  a_r5_start_follows_run_write: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o != '0) |-> $past(run_req));

  a_r10_oob_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rd && oob) |-> (bus_rdata == 32'd0));

  a_r6_run_implies_claim: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctrl_rd) |-> !(bus_rdata[1] && !bus_rdata[0]));

endmodule

bind dma_claim_ctrl dma_claim_ctrl_chk #(.NCH(NCH), .CHW(CHW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .start_o(start_o)
);

// File: tb/dma_claim_ctrl_test.sv
module dma_claim_ctrl_test;
  localparam int NCH = 3;
  localparam int CHW = 2;
  localparam int AW  = CHW + 5;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0]  bus_addr = '0;
  logic [31:0]    bus_wdata = '0;
  logic [31:0]    bus_rdata;
  logic [NCH-1:0] done_i = '0;
  logic [NCH-1:0] start_o;
  logic [63:0]    start_bytes_o, start_dst_o, start_src_o;
  logic [3:0]     start_wsize_o, start_rsize_o;

  always #2 clk = ~clk;

  dma_claim_ctrl #(.NCH(NCH), .CHW(CHW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .done_i(done_i), .start_o(start_o), .start_bytes_o(start_bytes_o),
    .start_dst_o(start_dst_o), .start_src_o(start_src_o),
    .start_wsize_o(start_wsize_o), .start_rsize_o(start_rsize_o)
  );

  int checks = 0, fails = 0;
  bit m_claim [NCH];
  bit m_run   [NCH];
  logic [3:0]  m_wsz [NCH];
  logic [3:0]  m_rsz [NCH];
  logic [63:0] m_nb  [NCH];
  logic [63:0] m_nd  [NCH];
  logic [63:0] m_ns  [NCH];

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk(input int c, input int off);
    return AW'((c << 5) | off);
  endfunction

  function automatic logic [31:0] exp_read(input logic [AW-1:0] a);
    int c = int'(a[AW-1:5]);
    if (c >= NCH) return 32'd0;
    case (a[4:2])
      3'd0: return {30'd0, m_run[c], m_claim[c]};
      3'd1: return {m_wsz[c], m_rsz[c], 24'd0};
      3'd2: return m_nb[c][31:0];
      3'd3: return m_nb[c][63:32];
      3'd4: return m_nd[c][31:0];
      3'd5: return m_nd[c][63:32];
      3'd6: return m_ns[c][31:0];
      default: return m_ns[c][63:32];
    endcase
  endfunction

  // returns channel that should start, or -1
  function automatic int model_write(input logic [AW-1:0] a, input logic [31:0] d);
    int c = int'(a[AW-1:5]);
    bit was;
    if (c >= NCH || m_run[c]) return -1;
    case (a[4:2])
      3'd0: begin
        was = m_claim[c];
        if (!was && d[0]) begin m_nb[c] = 0; m_nd[c] = 0; m_ns[c] = 0; end
        m_claim[c] = d[0];
        m_run[c] = was && d[0] && d[1];
        return m_run[c] ? c : -1;
      end
      3'd1: begin m_wsz[c] = d[31:28]; m_rsz[c] = d[27:24]; end
      3'd2: m_nb[c][31:0]  = d;
      3'd3: m_nb[c][63:32] = d;
      3'd4: m_nd[c][31:0]  = d;
      3'd5: m_nd[c][63:32] = d;
      3'd6: m_ns[c][31:0]  = d;
      default: m_ns[c][63:32] = d;
    endcase
    return -1;
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input string tag);
    int s;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    s = model_write(a, d);
    @(negedge clk);
    bus_wr = 1'b0;
    if (s < 0) check({tag, " R4 no start"}, 64'(start_o), 64'd0);
    else begin
      check({tag, " R5 start pulse"}, 64'(start_o), 64'(1 << s));
      check({tag, " R5 bytes"}, start_bytes_o, m_nb[s]);
      check({tag, " R5 dst"}, start_dst_o, m_nd[s]);
      check({tag, " R5 src"}, start_src_o, m_ns[s]);
      check({tag, " R5 sizes"}, 64'({start_wsize_o, start_rsize_o}), 64'({m_wsz[s], m_rsz[s]}));
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    check({tag, " R2 read"}, 64'(bus_rdata), 64'(exp_read(a)));
    check({tag, " R11 idle start"}, 64'(start_o), 64'd0);
  endtask

  task automatic done(input int c);
    @(negedge clk);
    done_i = NCH'(1 << c);
    if (m_run[c]) m_run[c] = 0;
    @(negedge clk);
    done_i = '0;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < NCH; i++) begin
      m_claim[i] = 0; m_run[i] = 0; m_wsz[i] = 0; m_rsz[i] = 0;
      m_nb[i] = 0; m_nd[i] = 0; m_ns[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 start after reset", 64'(start_o), 64'd0);
    for (int c = 0; c < NCH; c++)
      for (int o = 0; o < 32; o += 4) rd(mk(c, o), "R1 reset value");

    // claim, fill descriptor, then run without claim
    wr(mk(0, 0), 32'h1, "R3 claim");
    wr(mk(0, 4), 32'h5500_00ff, "R2 cfg");
    rd(mk(0, 4), "R2 cfg fields only");
    wr(mk(0, 8), 32'h2, "R2");
    wr(mk(0, 16), 32'h8400_0000, "R2");
    wr(mk(0, 24), 32'h8400_1000, "R2");
    wr(mk(0, 28), 32'hdead_beef, "R2 high word");
    rd(mk(0, 28), "R2 high word");
    wr(mk(0, 0), 32'h2, "R7 run without claim");
    rd(mk(0, 0), "R7 control reads 0");
    // re-claim clears descriptor
    wr(mk(0, 0), 32'h1, "R3 reclaim");
    rd(mk(0, 8), "R3 bytes cleared");
    rd(mk(0, 24), "R3 src cleared");
    wr(mk(0, 8), 32'h40, "R2");
    wr(mk(0, 12), 32'h1, "R2");
    wr(mk(0, 20), 32'h7, "R2");
    wr(mk(0, 0), 32'h3, "R5 start");
    wr(mk(0, 0), 32'h0, "R6 disclaim while running");
    rd(mk(0, 0), "R6 claim held");
    wr(mk(0, 8), 32'h999, "R9 write while running");
    wr(mk(0, 4), 32'h1100_0000, "R9 cfg while running");
    rd(mk(0, 8), "R9 bytes unchanged");
    rd(mk(0, 4), "R9 cfg unchanged");
    done(0);
    rd(mk(0, 0), "R8 done clears run");
    done(0);
    rd(mk(0, 0), "R8 idle done ignored");
    wr(mk(0, 0), 32'h0, "R7 disclaim");
    rd(mk(0, 0), "R7 reads 0");
    // run request on unclaimed channel
    wr(mk(1, 0), 32'h3, "R4 run on unclaimed");
    rd(mk(1, 0), "R4 run reads 0");
    // out-of-range channel
    wr(mk(3, 0), 32'h1, "R10 oob write");
    wr(mk(3, 8), 32'h55, "R10 oob write");
    rd(mk(3, 0), "R10 oob read");
    rd(mk(3, 8), "R10 oob read");
    for (int c = 0; c < NCH; c++) rd(mk(c, 8), "R10 no alias");

    for (int n = 0; n < 3000; n++) begin
      int c = int'($urandom % 4);
      int op = int'($urandom % 10);
      int off = int'($urandom % 8) * 4;
      logic [31:0] d = $urandom;
      if (op < 2) wr(mk(c, 0), {d[31:2], 2'(d % 4)}, "R5 rnd ctrl");
      else if (op < 5) wr(mk(c, off), d, "R9 rnd write");
      else if (op < 8) rd(mk(c, off), "R2 rnd read");
      else if (c < NCH) done(c);
      else rd(mk(c, off), "R10 rnd read");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule